// File: doc/BRIEF.md
# Byte-Addressable Banked Data Memory

This block is a 32-bit data memory that software addresses by byte. Its storage is four independent 8-bit banks working side by side, so an aligned word, an aligned halfword or any single byte is read or written in one clock cycle. No memory clock runs faster than the processor clock. All four banks see the same row number, which is the byte address with its two lowest bits dropped. Each bank owns one fixed byte lane of the 32-bit data path.

A read is combinational. It fetches the whole row from all four banks, keeps the lanes that the access size and offset select, and shifts them down into the low bits of the result. The upper bits are then filled with zeros or with copies of the sign bit. A write copies the store data onto every lane and raises the write enable only on the target banks. The other banks keep their contents.

An access that is not aligned to its size raises an error flag. The same happens with the unused size code. Such an access writes nothing and returns zero.

Top module: `byte_lane_mem`

## Requirements
- R1: While `rst_n` is low, every stored byte is cleared to zero. After reset, a word read at any aligned address returns 0 with `err` low.
- R2: The row number is `addr[ADDR_W-1:2]`. Lanes are little-endian: byte offset k (the value of `addr[1:0]`) is stored in bank k and appears on bits 8k+7:8k of a word read at the aligned address.
- R3: A word access (`size` = 2'b10) with `addr[1:0]` = 0 reads all four banks in the same cycle. When `we` is high it writes all four, and the new value is returned by a read of that row in the next cycle.
- R4: A halfword access (`size` = 2'b01) with `addr[0]` = 0 uses banks 0 and 1 when `addr[1]` is 0, and banks 2 and 3 when it is 1. A halfword write changes only those two banks.
- R5: A byte access (`size` = 2'b00) uses the single bank given by `addr[1:0]`. A byte write changes only that bank, and the other three bytes of the row keep their values.
- R6: For byte and halfword reads, the selected byte or halfword appears on `rdata[7:0]` or `rdata[15:0]`. With `sext` low, the remaining upper bits are zero.
- R7: With `sext` high, the upper bits of a byte read copy bit 7 of the selected byte, and the upper bits of a halfword read copy bit 15 of the selected halfword. Word reads ignore `sext`.
- R8: A misaligned or invalid access raises `err` in the same cycle, returns `rdata` = 0 and writes no bank. This covers a halfword with `addr[0]` = 1, a word with `addr[1:0]` != 0, and any access with `size` = 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Active-low reset; clears all storage |
| addr | input | ADDR_W | Byte address |
| size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 invalid |
| sext | input | 1 | Sign-extend byte and halfword reads when high |
| we | input | 1 | Write enable |
| wdata | input | 32 | Store data, taken from its low bits for narrow writes |
| rdata | output | 32 | Read data, aligned to bit 0 and extended |
| err | output | 1 | Misaligned or invalid access |

## Verification
The in-module assertions check these properties on every cycle:
- the zero or sign fill of narrow reads;
- the zero result of a flagged access;
- a word written in one cycle is read back the next;
- bytes outside the written lanes keep their values, and a flagged write leaves the row untouched.

Some properties depend on the data stored earlier, so only the bench's scenarios can show them:
- the little-endian mapping of offsets to lanes;
- which banks a halfword selects;
- the exact cases that count as misaligned;
- the cleared contents after reset.

The bench checks these by comparing every cycle against a byte-array model.

// File: rtl/byte_lane_mem.sv
module byte_lane_mem #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              sext,
  input  logic              we,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              err
);
  localparam int ROW_W = ADDR_W - 2;
  localparam int ROWS  = 1 << ROW_W;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  logic [ROW_W-1:0] row;
  logic [1:0]       ofs;
  logic [3:0]       lane_sel, lane_we;
  logic [31:0]      lane_wdata, raw, shifted;

  assign row = addr[ADDR_W-1:2];
  assign ofs = addr[1:0];

  always_comb begin
    case (size)
      SZ_BYTE: begin err = 1'b0;   lane_sel = 4'b0001 << ofs; lane_wdata = {4{wdata[7:0]}}; end
      SZ_HALF: begin err = ofs[0]; lane_sel = ofs[1] ? 4'b1100 : 4'b0011; lane_wdata = {2{wdata[15:0]}}; end
      SZ_WORD: begin err = |ofs;   lane_sel = 4'b1111; lane_wdata = wdata; end
      default: begin err = 1'b1;   lane_sel = 4'b0000; lane_wdata = wdata; end
    endcase
  end

  assign lane_we = (we && !err) ? lane_sel : 4'b0000;

  for (genvar g = 0; g < 4; g++) begin : g_bank
    logic [7:0] cells [ROWS];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int r = 0; r < ROWS; r++) cells[r] <= 8'h00;
      end else if (lane_we[g]) begin
        cells[row] <= lane_wdata[8*g +: 8];
      end
    end
    assign raw[8*g +: 8] = cells[row];
  end

  assign shifted = raw >> {ofs, 3'b000};

  always_comb begin
    if (err)                 rdata = '0;
    else if (size == SZ_BYTE) rdata = {{24{sext & shifted[7]}}, shifted[7:0]};
    else if (size == SZ_HALF) rdata = {{16{sext & shifted[15]}}, shifted[15:0]};
    else                      rdata = raw;
  end

  function automatic logic [31:0] lane_mask(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  assert_byte_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZ_BYTE && !sext) |-> rdata[31:8] == 24'h0);
  assert_half_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZ_HALF && !sext) |-> rdata[31:16] == 16'h0);
  assert_byte_sign_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZ_BYTE && sext) |-> rdata[31:8] == {24{rdata[7]}});
  assert_half_sign_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZ_HALF && sext && !err) |-> rdata[31:16] == {16{rdata[15]}});
  assert_err_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rdata == 32'h0);
  assert_word_write_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !err && size == SZ_WORD) |=>
      ((addr == $past(addr) && size == SZ_WORD) -> rdata == $past(wdata)));
  assert_err_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && err) |=>
      ((row == $past(row) && size == SZ_WORD && ofs == 2'b00) -> rdata == $past(raw)));
  assert_other_lanes_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !err) |=>
      ((row == $past(row) && size == SZ_WORD && ofs == 2'b00) ->
        (rdata & ~lane_mask($past(lane_we))) == ($past(raw) & ~lane_mask($past(lane_we)))));
endmodule

// File: tb/byte_lane_mem_test.sv
`timescale 1ns/1ps
module byte_lane_mem_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = 2'b10;
  logic        sext = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;

  int total = 0;
  int fails = 0;
  logic [7:0] model [256];

  always #2.5 clk = ~clk;

  byte_lane_mem #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .size(size), .sext(sext),
    .we(we), .wdata(wdata), .rdata(rdata), .err(err)
  );

  function automatic logic is_bad(input logic [7:0] a, input logic [1:0] s);
    if (s == 2'b00) return 1'b0;
    if (s == 2'b01) return a[0];
    if (s == 2'b10) return a[1:0] != 2'b00;
    return 1'b1;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a, input logic [1:0] s, input logic x);
    logic [7:0] b;
    logic [31:0] w;
    b = {a[7:2], 2'b00};
    w = {model[b+3], model[b+2], model[b+1], model[b]};
    if (is_bad(a, s)) return 32'h0;
    if (s == 2'b10) return w;
    if (s == 2'b00) return {{24{x & model[a][7]}}, model[a]};
    return {{16{x & model[a+1][7]}}, model[a+1], model[a]};
  endfunction

  task automatic step(input logic [7:0] a, input logic [1:0] s, input logic x,
                      input logic w, input logic [31:0] d, input string tag);
    logic [31:0] exp_d;
    logic exp_e;
    @(negedge clk);
    addr = a; size = s; sext = x; we = w; wdata = d;
    #1;
    exp_d = model_read(a, s, x);
    exp_e = is_bad(a, s);
    total++;
    if (rdata !== exp_d) begin
      fails++;
      $display("FAIL %s rdata addr=%h size=%b: actual %h expected %h", tag, a, s, rdata, exp_d);
    end
    total++;
    if (err !== exp_e) begin
      fails++;
      $display("FAIL %s err addr=%h size=%b: actual %b expected %b", tag, a, s, err, exp_e);
    end
    @(posedge clk);
    if (w && !exp_e) begin
      if (s == 2'b00) model[a] = d[7:0];
      else if (s == 2'b01) begin model[a] = d[7:0]; model[a+1] = d[15:8]; end
      else for (int k = 0; k < 4; k++) model[a+k] = d[8*k +: 8];
    end
  endtask

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: cleared after reset
    step(8'h00, 2'b10, 0, 0, 0, "R1");
    step(8'hFC, 2'b10, 0, 0, 0, "R1");
    step(8'h40, 2'b10, 0, 0, 0, "R1");
    // R3: word writes and read-back
    step(8'h10, 2'b10, 0, 1, 32'hDEADBEEF, "R3");
    step(8'h10, 2'b10, 0, 0, 0, "R3");
    step(8'hFC, 2'b10, 0, 1, 32'h80FF7F01, "R3");
    step(8'hFC, 2'b10, 1, 0, 0, "R3");
    // R2: lane mapping through byte reads of a word
    for (int k = 0; k < 4; k++) step(8'h10 + k[7:0], 2'b00, 0, 0, 0, "R2");
    // R5: byte writes touch only one lane
    step(8'h20, 2'b10, 0, 1, 32'h11223344, "R5");
    step(8'h22, 2'b00, 0, 1, 32'hFFFFFFAA, "R5");
    step(8'h20, 2'b10, 0, 0, 0, "R5");
    step(8'h23, 2'b00, 0, 1, 32'h000000C5, "R5");
    step(8'h20, 2'b10, 0, 0, 0, "R5");
    // R4: halfword lanes
    step(8'h30, 2'b10, 0, 1, 32'h0, "R4");
    step(8'h32, 2'b01, 0, 1, 32'h1234ABCD, "R4");
    step(8'h30, 2'b10, 0, 0, 0, "R4");
    step(8'h30, 2'b01, 0, 1, 32'hFFFF8001, "R4");
    step(8'h30, 2'b10, 0, 0, 0, "R4");
    // R6 and R7: zero and sign fill
    step(8'h32, 2'b01, 0, 0, 0, "R6");
    step(8'h32, 2'b01, 1, 0, 0, "R7");
    step(8'h30, 2'b01, 1, 0, 0, "R7");
    step(8'hFF, 2'b00, 0, 0, 0, "R6");
    step(8'hFF, 2'b00, 1, 0, 0, "R7");
    step(8'hFE, 2'b00, 1, 0, 0, "R7");
    step(8'hFC, 2'b10, 1, 0, 0, "R7");
    // R8: misaligned and invalid accesses write nothing
    step(8'h21, 2'b01, 0, 1, 32'hFFFFFFFF, "R8");
    step(8'h22, 2'b10, 0, 1, 32'hFFFFFFFF, "R8");
    step(8'h21, 2'b10, 1, 1, 32'hFFFFFFFF, "R8");
    step(8'h20, 2'b11, 0, 1, 32'hFFFFFFFF, "R8");
    step(8'h20, 2'b10, 0, 0, 0, "R8");
    // mixed traffic
    for (int n = 0; n < 400; n++)
      step($urandom_range(0, 255), $urandom_range(0, 3), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom, "MIX");
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule